// File: doc/BRIEF.md
# Chip-Select Bus Cycle Terminator

This block runs one external bus cycle for a single chip-select region of an asynchronous microcontroller-style bus. It steps through the cycle's half-clock states and drives the address strobe, the data strobe and the chip-select. It also produces the two-line data-size acknowledge that ends the cycle. Each tick of `clk` is one half-clock bus state. A cycle is `S0 S1 S2 S3 S4 S5`, with optional wait-state pairs `W0 W1` inserted between `S2` and `S3`.

A 4-bit acknowledge code sets how the region ends its cycles. Codes 0 to 13 give an internal acknowledge after that many wait states. Code 14 gives fast termination: a four-tick cycle with no `S2`/`S3`. Code 15 leaves the internal acknowledge off, so only the external device can end the cycle. The external acknowledge lines are watched in every mode and are merged onto the acknowledge output. A 2-bit strobe-select code decides whether the chip-select follows the address strobe or the data strobe. Read data is captured at the end of `S4`.

The options are captured when a cycle starts. A start request made while a cycle is in progress is ignored.

Top module: `csterm_top`

## Requirements
- R1: While `rstN` is low, `busState` is 0 (idle). `asN`, `dsN` and `csN` are 1 and `dsackN` is 2'b11 whatever `extAckN` is. `rdData` is 0 after reset.
- R2: `startReq` seen at a rising edge while idle starts a cycle. With acknowledge code 0 the states are S0, S1, S2, S3, S4, S5, one tick each, and then idle. The state codes are idle 0, S0 1, S1 2, S2 3, W0 4, W1 5, S3 6, S4 7, S5 8.
- R3: Acknowledge code k (0..13) with no external acknowledge inserts exactly k pairs W0, W1 between S2 and S3. The cycle then lasts 6+2k ticks.
- R4: Acknowledge code 14 (fast termination) runs S0, S1, S4, S5 and ignores the external lines for sequencing.
- R5: The external acknowledge (`extAckN` not equal to 2'b11) is sampled at the end of S2 and at the end of each W1. When seen there, it moves the cycle to S3 in codes 0..13 and 15. The cycle ends at the earlier of the internal and external acknowledge. Code 15 waits for the external acknowledge alone.
- R6: `asN` is 0 exactly in S1, S2, W0, W1, S3 and S4.
- R7: For reads, `dsN` equals `asN`. For non-fast writes, `dsN` is 0 only in S3 and S4. For fast writes, `dsN` stays 1.
- R8: Strobe-select 2'b01 makes `csN` follow `asN`. 2'b10 makes it follow `dsN`, so a fast write gives no chip-select. 2'b00 and 2'b11 keep `csN` at 1.
- R9: The internal acknowledge is 2'b00 for a 16-bit port (`port16`=1) and 2'b10 for an 8-bit port. It is driven in S1 and S4 for code 14. For codes 0..13 it is driven in S3 and S4, but only if the internal count expired at the sampling point that ended the wait. It is never driven for code 15.
- R10: `dsackN` is the bitwise AND of the internal acknowledge and `extAckN` while `asN` is 0. It equals the internal acknowledge alone while `asN` is 1.
- R11: For reads, `rdData` takes the `dataIn` value present at the end of S4. Writes leave `rdData` unchanged.
- R12: `startReq` and the option inputs (`rdWr`, `port16`, `strobeSel`, `ackCode`) have no effect once a cycle has started.
- R13: `cycleDone` is 1 exactly in S5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Half-state tick clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startReq | input | 1 | Request to start a cycle (taken when idle) |
| rdWr | input | 1 | 1 = read, 0 = write |
| port16 | input | 1 | 1 = 16-bit port, 0 = 8-bit port |
| strobeSel | input | 2 | Chip-select strobe source: 01 address, 10 data, else off |
| ackCode | input | 4 | Wait count 0..13, 14 fast, 15 external only |
| extAckN | input | 2 | External acknowledge lines, active low |
| dataIn | input | DATA_W | Read data from the bus |
| asN | output | 1 | Address strobe, active low |
| dsN | output | 1 | Data strobe, active low |
| csN | output | 1 | Chip-select, active low |
| dsackN | output | 2 | Merged acknowledge, active low |
| busState | output | 4 | Current bus state code |
| cycleDone | output | 1 | High during S5 |
| rdData | output | DATA_W | Captured read data |

## Verification
The bound checker checks the state-to-state rules on every cycle. These are S0 always followed by S1, W0 always followed by W1, and S1 followed only by S2 or S4. It also checks the strobe rules: the address strobe matches the active states, the data strobe never asserts without the address strobe, and the acknowledge is quiet outside the address phase. Two more per-cycle checks cover `cycleDone` matching S5 and `rdData` changing only after S4. The bench alone can show the exact cycle lengths for each wait code, and which of internal or external acknowledge wins. Only the bench shows the acknowledge encoding per port size, the chip-select choice per strobe select, and that options changed mid-cycle are ignored.

// File: rtl/csterm_pkg.sv
package csterm_pkg;

  typedef enum logic [3:0] {
    ST_IDLE = 4'd0,
    ST_S0   = 4'd1,
    ST_S1   = 4'd2,
    ST_S2   = 4'd3,
    ST_W0   = 4'd4,
    ST_W1   = 4'd5,
    ST_S3   = 4'd6,
    ST_S4   = 4'd7,
    ST_S5   = 4'd8
  } busStateE;

  localparam logic [1:0] SEL_ADDR = 2'b01;
  localparam logic [1:0] SEL_DATA = 2'b10;

  localparam logic [1:0] ACK_WORD = 2'b00;
  localparam logic [1:0] ACK_BYTE = 2'b10;
  localparam logic [1:0] ACK_NONE = 2'b11;

  typedef struct packed {
    logic loadCfg;    // capture options at cycle start
    logic addrPhase;  // address strobe window
    logic dataPhase;  // write data strobe window
    logic fastCycle;  // fast termination in effect
    logic intAckOn;   // drive internal acknowledge
    logic capture;    // sample read data
  } ctlStrobesT;

endpackage

// File: rtl/csterm_ctrl.sv
module csterm_ctrl
  import csterm_pkg::*;
#(
  parameter int WAIT_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  input  logic [1:0]        extAckN,
  input  logic [WAIT_W-1:0] ackCodeQ,
  output ctlStrobesT        strobes,
  output busStateE          state
);

  localparam logic [WAIT_W-1:0] EXT_ONLY  = {WAIT_W{1'b1}};
  localparam logic [WAIT_W-1:0] FAST_CODE = EXT_ONLY - 1'b1;

  busStateE          stateNext;
  logic [WAIT_W-1:0] waitLeft;
  logic              intHit;
  logic              fastMode;
  logic              intMode;
  logic              extSeen;
  logic              intReady;
  logic              ackNow;
  logic              samplePoint;

  assign fastMode    = (ackCodeQ == FAST_CODE);
  assign intMode     = (ackCodeQ < FAST_CODE);
  assign extSeen     = (extAckN != ACK_NONE);
  assign intReady    = intMode && (waitLeft == '0);
  assign ackNow      = extSeen || intReady;
  assign samplePoint = (state == ST_S2) || (state == ST_W1);

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE: if (startReq) stateNext = ST_S0;
      ST_S0:   stateNext = ST_S1;
      ST_S1:   stateNext = fastMode ? ST_S4 : ST_S2;
      ST_S2:   stateNext = ackNow ? ST_S3 : ST_W0;
      ST_W0:   stateNext = ST_W1;
      ST_W1:   stateNext = ackNow ? ST_S3 : ST_W0;
      ST_S3:   stateNext = ST_S4;
      ST_S4:   stateNext = ST_S5;
      ST_S5:   stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      waitLeft <= '0;
      intHit   <= 1'b0;
    end else begin
      state <= stateNext;
      if (state == ST_S0) begin
        waitLeft <= ackCodeQ;
        intHit   <= 1'b0;
      end else if (state == ST_W0 && waitLeft != '0) begin
        waitLeft <= waitLeft - 1'b1;
      end
      if (samplePoint && ackNow) intHit <= intReady;
    end
  end

  always_comb begin
    strobes.loadCfg   = (state == ST_IDLE) && startReq;
    strobes.addrPhase = (state == ST_S1) || (state == ST_S2) ||
                        (state == ST_W0) || (state == ST_W1) ||
                        (state == ST_S3) || (state == ST_S4);
    strobes.dataPhase = (state == ST_S3) || (state == ST_S4);
    strobes.fastCycle = fastMode;
    strobes.intAckOn  = (fastMode && ((state == ST_S1) || (state == ST_S4))) ||
                        (intHit && strobes.dataPhase);
    strobes.capture   = (state == ST_S4);
  end

endmodule

// File: rtl/csterm_dpath.sv
module csterm_dpath
  import csterm_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int WAIT_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobesT        strobes,
  input  logic              rdWr,
  input  logic              port16,
  input  logic [1:0]        strobeSel,
  input  logic [WAIT_W-1:0] ackCode,
  input  logic [1:0]        extAckN,
  input  logic [DATA_W-1:0] dataIn,
  output logic [WAIT_W-1:0] ackCodeQ,
  output logic              asN,
  output logic              dsN,
  output logic              csN,
  output logic [1:0]        dsackN,
  output logic [DATA_W-1:0] rdData
);

  logic       rdQ;
  logic       port16Q;
  logic [1:0] selQ;
  logic [1:0] intAckN;
  logic       dsActive;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdQ      <= 1'b0;
      port16Q  <= 1'b0;
      selQ     <= 2'b00;
      ackCodeQ <= '0;
    end else if (strobes.loadCfg) begin
      rdQ      <= rdWr;
      port16Q  <= port16;
      selQ     <= strobeSel;
      ackCodeQ <= ackCode;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdData <= '0;
    else if (strobes.capture && rdQ) rdData <= dataIn;
  end

  assign dsActive = rdQ ? strobes.addrPhase
                        : (strobes.dataPhase && !strobes.fastCycle);

  assign asN = !strobes.addrPhase;
  assign dsN = !dsActive;

  always_comb begin
    unique case (selQ)
      SEL_ADDR: csN = asN;
      SEL_DATA: csN = dsN;
      default:  csN = 1'b1;
    endcase
  end

  assign intAckN = !strobes.intAckOn ? ACK_NONE : (port16Q ? ACK_WORD : ACK_BYTE);
  assign dsackN  = intAckN & (asN ? ACK_NONE : extAckN);

endmodule

// File: rtl/csterm_top.sv
module csterm_top
  import csterm_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int WAIT_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  input  logic              rdWr,
  input  logic              port16,
  input  logic [1:0]        strobeSel,
  input  logic [WAIT_W-1:0] ackCode,
  input  logic [1:0]        extAckN,
  input  logic [DATA_W-1:0] dataIn,
  output logic              asN,
  output logic              dsN,
  output logic              csN,
  output logic [1:0]        dsackN,
  output logic [3:0]        busState,
  output logic              cycleDone,
  output logic [DATA_W-1:0] rdData
);

  ctlStrobesT        strobes;
  busStateE          state;
  logic [WAIT_W-1:0] ackCodeQ;

  csterm_ctrl #(.WAIT_W(WAIT_W)) ctrl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .extAckN(extAckN),
    .ackCodeQ(ackCodeQ), .strobes(strobes), .state(state)
  );

  csterm_dpath #(.DATA_W(DATA_W), .WAIT_W(WAIT_W)) dpath (
    .clk(clk), .rstN(rstN), .strobes(strobes), .rdWr(rdWr), .port16(port16),
    .strobeSel(strobeSel), .ackCode(ackCode), .extAckN(extAckN), .dataIn(dataIn),
    .ackCodeQ(ackCodeQ), .asN(asN), .dsN(dsN), .csN(csN), .dsackN(dsackN),
    .rdData(rdData)
  );

  assign busState  = state;
  assign cycleDone = (state == ST_S5);

endmodule

// File: rtl/csterm_checker.sv
module csterm_checker
  import csterm_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              asN,
  input logic              dsN,
  input logic              csN,
  input logic [1:0]        dsackN,
  input logic [3:0]        busState,
  input logic              cycleDone,
  input logic [DATA_W-1:0] rdData
);

  logic inAddr;
  assign inAddr = (busState == 4'(ST_S1)) || (busState == 4'(ST_S2)) ||
                  (busState == 4'(ST_W0)) || (busState == 4'(ST_W1)) ||
                  (busState == 4'(ST_S3)) || (busState == 4'(ST_S4));

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rstN |-> (asN && dsN && csN && dsackN == 2'b11 && busState == 4'(ST_IDLE))); // R1

  AST_S0_THEN_S1: assert property (@(posedge clk) disable iff (!rstN)
    busState == 4'(ST_S0) |=> busState == 4'(ST_S1)); // R2

  AST_WAIT_PAIR: assert property (@(posedge clk) disable iff (!rstN)
    busState == 4'(ST_W0) |=> busState == 4'(ST_W1)); // R3

  AST_S1_EXIT: assert property (@(posedge clk) disable iff (!rstN)
    busState == 4'(ST_S1) |=> (busState == 4'(ST_S2) || busState == 4'(ST_S4))); // R4

  AST_AS_WINDOW: assert property (@(posedge clk) disable iff (!rstN)
    inAddr == !asN); // R6

  AST_DS_NEEDS_AS: assert property (@(posedge clk) disable iff (!rstN)
    !dsN |-> !asN); // R7

  AST_CS_NEEDS_AS: assert property (@(posedge clk) disable iff (!rstN)
    !csN |-> !asN); // R8

  AST_ACK_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    asN |-> dsackN == 2'b11); // R10

  AST_RD_AFTER_S4: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(rdData) |-> $past(busState) == 4'(ST_S4)); // R11

  AST_DONE_S5: assert property (@(posedge clk) disable iff (!rstN)
    cycleDone == (busState == 4'(ST_S5))); // R13

endmodule

bind csterm_top csterm_checker #(.DATA_W(DATA_W)) checkerInst (
  .clk(clk), .rstN(rstN), .asN(asN), .dsN(dsN), .csN(csN), .dsackN(dsackN),
  .busState(busState), .cycleDone(cycleDone), .rdData(rdData)
);

// File: tb/csterm_top_test.sv
module csterm_top_test;

  localparam int DW = 16;
  localparam int NO_EXT = 99;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          startReq = 1'b0;
  logic          rdWr = 1'b0;
  logic          port16 = 1'b0;
  logic [1:0]    strobeSel = 2'b00;
  logic [3:0]    ackCode = 4'd0;
  logic [1:0]    extAckN = 2'b11;
  logic [DW-1:0] dataIn = '0;
  logic          asN, dsN, csN, cycleDone;
  logic [1:0]    dsackN;
  logic [3:0]    busState;
  logic [DW-1:0] rdData;

  int checks = 0;
  int errors = 0;
  logic [DW-1:0] lastRd = '0;

  always #5 clk = ~clk;

  csterm_top #(.DATA_W(DW), .WAIT_W(4)) uut (
    .clk(clk), .rstN(rstN), .startReq(startReq), .rdWr(rdWr), .port16(port16),
    .strobeSel(strobeSel), .ackCode(ackCode), .extAckN(extAckN), .dataIn(dataIn),
    .asN(asN), .dsN(dsN), .csN(csN), .dsackN(dsackN), .busState(busState),
    .cycleDone(cycleDone), .rdData(rdData)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  function automatic int expState(input int t, input bit fast, input int w);
    if (fast) begin
      case (t)
        0: return 1;
        1: return 2;
        2: return 7;
        default: return 8;
      endcase
    end
    if (t < 3) return t + 1;
    if (t < 3 + 2 * w) return ((t - 3) % 2 == 0) ? 4 : 5;
    return 6 + (t - 3 - 2 * w);
  endfunction

  task automatic runCycle(input bit rd, input bit p16, input logic [1:0] sel,
                          input int code, input int e, input logic [DW-1:0] data);
    bit fast = (code == 14);
    bit intMode = (code < 14);
    int w;
    bit intHit;
    int len;
    logic [1:0] extVal = p16 ? 2'b00 : 2'b10;
    logic [1:0] sizeAck = p16 ? 2'b00 : 2'b10;
    if (fast) w = 0;
    else if (intMode) w = (code < e) ? code : e;
    else w = e;
    intHit = intMode && (code <= e);
    len = fast ? 4 : 6 + 2 * w;

    @(negedge clk);
    rdWr = rd; port16 = p16; strobeSel = sel; ackCode = 4'(code);
    dataIn = data; startReq = 1'b1;
    for (int t = 0; t < len; t++) begin
      @(negedge clk);
      // R12: scramble inputs while a cycle runs; start held high until the final tick
      rdWr = ~rd; port16 = ~p16; strobeSel = ~sel; ackCode = ~4'(code);
      startReq = (t < len - 1);
      extAckN = (t >= 2 + 2 * e) ? extVal : 2'b11;
      #1;
      begin
        int st = expState(t, fast, w);
        bit asLow = (st >= 2 && st <= 7);
        bit dLow = rd ? asLow : ((st == 6 || st == 7) && !fast);
        bit csLow = (sel == 2'b01) ? asLow : (sel == 2'b10) ? dLow : 1'b0;
        bit intOn = (fast && (st == 2 || st == 7)) || (intHit && (st == 6 || st == 7));
        logic [1:0] iAck = intOn ? sizeAck : 2'b11;
        logic [1:0] expAck = iAck & (asLow ? extAckN : 2'b11);
        chk(busState == 4'(st), "R2/R3/R4/R5 state", int'(busState), st);
        chk(asN == !asLow, "R6 asN", int'(asN), int'(!asLow));
        chk(dsN == !dLow, "R7 dsN", int'(dsN), int'(!dLow));
        chk(csN == !csLow, "R8 csN", int'(csN), int'(!csLow));
        chk(dsackN == expAck, "R9/R10 dsackN", int'(dsackN), int'(expAck));
        chk(cycleDone == (st == 8), "R13 cycleDone", int'(cycleDone), int'(st == 8));
      end
    end
    @(negedge clk);
    startReq = 1'b0; extAckN = 2'b11;
    #1;
    if (rd) lastRd = data;
    chk(busState == 4'd0, "R2 return to idle (R12 no restart)", int'(busState), 0);
    chk(rdData == lastRd, "R11 rdData", int'(rdData), int'(lastRd));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int codes[7] = '{0, 1, 2, 5, 13, 14, 15};
    int seed = 0;
    extAckN = 2'b00;
    repeat (3) @(negedge clk);
    #1;
    // R1: reset state with external acknowledge held asserted
    chk(busState == 4'd0, "R1 state", int'(busState), 0);
    chk({asN, dsN, csN} == 3'b111, "R1 strobes", int'({asN, dsN, csN}), 7);
    chk(dsackN == 2'b11, "R1 dsackN", int'(dsackN), 3);
    chk(rdData == '0, "R1 rdData", int'(rdData), 0);
    extAckN = 2'b11;
    @(negedge clk);
    rstN = 1'b1;

    for (int rd = 0; rd < 2; rd++)
      for (int p = 0; p < 2; p++)
        for (int s = 0; s < 4; s++)
          for (int ci = 0; ci < 7; ci++) begin
            int c = codes[ci];
            seed++;
            if (c == 15) begin
              runCycle(rd[0], p[0], 2'(s), c, 0, 16'(seed * 16'h3A5 + 16'h11));   // R5
              runCycle(rd[0], p[0], 2'(s), c, 3, 16'(seed * 16'h1C7 + 16'h2B));   // R5
            end else begin
              runCycle(rd[0], p[0], 2'(s), c, NO_EXT, 16'(seed * 16'h0F3 + 16'h5)); // R3 R4
              runCycle(rd[0], p[0], 2'(s), c, 1, 16'(seed * 16'h2D1 + 16'h7));      // R5 R10
            end
          end

    // R1: reset in the middle of a wait cycle, external acknowledge asserted
    @(negedge clk);
    rdWr = 1'b1; port16 = 1'b1; strobeSel = 2'b01; ackCode = 4'd5; startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    repeat (4) @(negedge clk);
    extAckN = 2'b00;
    rstN = 1'b0;
    #1;
    chk(busState == 4'd0, "R1 mid-cycle state", int'(busState), 0);
    chk({asN, dsN, csN} == 3'b111, "R1 mid-cycle strobes", int'({asN, dsN, csN}), 7);
    chk(dsackN == 2'b11, "R1 mid-cycle dsackN", int'(dsackN), 3);
    chk(rdData == '0, "R1 mid-cycle rdData", int'(rdData), 0);
    @(negedge clk);
    extAckN = 2'b11;
    rstN = 1'b1;
    lastRd = '0;
    runCycle(1'b1, 1'b0, 2'b10, 0, NO_EXT, 16'hBEEF); // R2 R11 after reset

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule